// File: doc/BRIEF.md
# Hierarchical Frame Timer

This block keeps radio frame time as four cascaded counters: a sub-chip divider stepped by the reference clock, a chip counter, a slot counter and a frame counter. Each counter climbs to its own terminal value, returns to zero and carries one step into the next counter up. The slot counter is the one exception to a fixed limit upstream of it: the chip counter's limit is taken from a small circular table, and the table pointer moves one entry each time a slot ends. Slots inside one frame can therefore have different chip lengths.

Alignment to the outside world comes from a sync input. A rising level on `sync_in` is taken as a frame boundary. After an optional delay of 0 to 16 clock cycles, every counter loads its programmed start value and the table pointer returns to entry 0. Counting and strobe generation need the block to be armed. A separate halt input freezes the counters while still accepting a sync load. The outputs are the four count fields, the table pointer, and registered one-cycle strobes that mark chip, slot and frame wraps.

Top module: `frame_timebase`

## Requirements
- R1: After reset every count field and the table pointer read 0, and all three strobes are low.
- R2: While armed and not halted, `sub_cnt` advances by one per clock. At the edge where it equals `sub_tc` it returns to 0 and the chip counter advances.
- R3: The chip counter returns to 0 on the sub-chip carry that finds it equal to the table entry selected by `tbl_idx`, and the slot counter advances. An entry written through `tbl_we`/`tbl_addr`/`tbl_data` is used from the next cycle on.
- R4: Each chip wrap moves `tbl_idx` to the next entry. It goes back to 0 after the entry numbered `tbl_last`, so with `tbl_last` = 0 it stays at 0.
- R5: The slot counter returns to 0 on a chip carry that finds it equal to `slot_tc`, and the frame counter advances.
- R6: The frame counter returns to 0 on a slot carry that finds it equal to `frame_tc`.
- R7: A 0-to-1 change of `sync_in` seen at a clock edge with `sync_dly` = 0 loads `init_sub`, `init_chip`, `init_slot` and `init_frame` at that same edge and sets `tbl_idx` to 0. No strobe follows a load.
- R8: With `sync_dly` = D > 0 the load happens D edges after the edge that saw the rising sync. A newer rising sync restarts the wait.
- R9: While `halt` is 1 the count fields and pointer stay fixed and no strobe is produced. A sync load is still taken.
- R10: While `arm` is 0 the counters stay fixed, no strobe is produced, and sync edges are neither taken nor remembered.
- R11: `chip_stb`, `slot_stb` and `frame_stb` are each high for exactly the cycle that follows the edge at which the matching counter wrapped, so they coincide with the wrapped-to-zero values. A frame strobe always comes with slot and chip strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Enables counting, strobes and sync acceptance |
| halt | input | 1 | Freezes counters and strobes; sync loads still taken |
| sync_in | input | 1 | Frame sync; a rising level marks a boundary |
| sync_dly | input | 5 | Sync delay in clock cycles, 0 to 16 |
| sub_tc | input | 8 | Sub-chip terminal count |
| slot_tc | input | 8 | Slot terminal count |
| frame_tc | input | 12 | Frame terminal count |
| tbl_we | input | 1 | Chip table write strobe |
| tbl_addr | input | 2 | Chip table write address |
| tbl_data | input | 16 | Chip terminal count to write |
| tbl_last | input | 2 | Number of the last active table entry |
| init_sub | input | 8 | Sub-chip value loaded on sync |
| init_chip | input | 16 | Chip value loaded on sync |
| init_slot | input | 8 | Slot value loaded on sync |
| init_frame | input | 12 | Frame value loaded on sync |
| sub_cnt | output | 8 | Current sub-chip count |
| chip_cnt | output | 16 | Current chip count |
| slot_cnt | output | 8 | Current slot count |
| frame_cnt | output | 12 | Current frame count |
| tbl_idx | output | 2 | Current chip table entry |
| chip_stb | output | 1 | One-cycle chip wrap strobe |
| slot_stb | output | 1 | One-cycle slot wrap strobe |
| frame_stb | output | 1 | One-cycle frame wrap strobe |

## Verification
Every output is registered. A count change caused by the inputs at one edge is visible in the following cycle, and a strobe appears in that same cycle next to the zeroed count. A sync load shows up after edge number D counted from the edge that saw the rising sync, where D = 0 means that edge itself. The bench drives inputs and reads outputs on falling edges. A behavioural model advances at each rising edge from the same inputs, so every comparison lines up with the edge that produced the value. The delayed-sync case is also checked by hand after each of the D edges while counting is halted.

// File: rtl/ft_pkg.sv
package ft_pkg;
  localparam int unsigned FT_SUB_W   = 8;
  localparam int unsigned FT_CHIP_W  = 16;
  localparam int unsigned FT_SLOT_W  = 8;
  localparam int unsigned FT_FRAME_W = 12;
  localparam int unsigned FT_TBL_N   = 4;
  localparam int unsigned FT_MAX_DLY = 16;
endpackage

// File: rtl/ft_level.sv
module ft_level #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] tc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_d;

  assign wrap = step && (cnt == tc);

  always_comb begin
    cnt_d = cnt;
    if (load)      cnt_d = load_val;
    else if (wrap) cnt_d = '0;
    else if (step) cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/ft_chip_table.sv
module ft_chip_table #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 16,
  parameter int unsigned IW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] last,
  input  logic          advance,
  input  logic          clear,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  tc
);
  logic [W-1:0]  ent [DEPTH];
  logic [IW-1:0] idx_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ent[g] <= '0;
      else if (we && (waddr == IW'(g)))        ent[g] <= wdata;
    end
  end

  assign tc = ent[idx];

  always_comb begin
    idx_d = idx;
    if (clear)               idx_d = '0;
    else if (advance) begin
      if (idx >= last)       idx_d = '0;
      else                   idx_d = idx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_d;
  end
endmodule

// File: rtl/ft_sync_delay.sv
module ft_sync_delay #(
  parameter int unsigned DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sync_in,
  input  logic [DW-1:0] dly,
  output logic          fire
);
  logic          sync_q, pend_q, pend_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          rise;

  assign rise = en && sync_in && !sync_q;
  assign fire = en && ((rise && (dly == '0)) || (pend_q && (cnt_q == DW'(1))));

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (!en) begin
      pend_d = 1'b0;
    end else if (rise && (dly != '0)) begin
      pend_d = 1'b1;
      cnt_d  = dly;
    end else if (pend_q) begin
      if (cnt_q == DW'(1)) pend_d = 1'b0;
      else                 cnt_d  = cnt_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_in;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/frame_timebase.sv
module frame_timebase #(
  parameter int unsigned SUB_W   = ft_pkg::FT_SUB_W,
  parameter int unsigned CHIP_W  = ft_pkg::FT_CHIP_W,
  parameter int unsigned SLOT_W  = ft_pkg::FT_SLOT_W,
  parameter int unsigned FRAME_W = ft_pkg::FT_FRAME_W,
  parameter int unsigned TBL_N   = ft_pkg::FT_TBL_N,
  parameter int unsigned MAX_DLY = ft_pkg::FT_MAX_DLY,
  localparam int unsigned IDX_W  = (TBL_N > 1) ? $clog2(TBL_N) : 1,
  localparam int unsigned DLY_W  = $clog2(MAX_DLY + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               halt,
  input  logic               sync_in,
  input  logic [DLY_W-1:0]   sync_dly,
  input  logic [SUB_W-1:0]   sub_tc,
  input  logic [SLOT_W-1:0]  slot_tc,
  input  logic [FRAME_W-1:0] frame_tc,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_addr,
  input  logic [CHIP_W-1:0]  tbl_data,
  input  logic [IDX_W-1:0]   tbl_last,
  input  logic [SUB_W-1:0]   init_sub,
  input  logic [CHIP_W-1:0]  init_chip,
  input  logic [SLOT_W-1:0]  init_slot,
  input  logic [FRAME_W-1:0] init_frame,
  output logic [SUB_W-1:0]   sub_cnt,
  output logic [CHIP_W-1:0]  chip_cnt,
  output logic [SLOT_W-1:0]  slot_cnt,
  output logic [FRAME_W-1:0] frame_cnt,
  output logic [IDX_W-1:0]   tbl_idx,
  output logic               chip_stb,
  output logic               slot_stb,
  output logic               frame_stb
);
  logic              fire, adv;
  logic              sub_wrap, chip_wrap, slot_wrap, frame_wrap;
  logic [CHIP_W-1:0] chip_tc;
  logic [2:0]        stb_d, stb_q;

  assign adv = arm && !halt;

  ft_sync_delay #(.DW(DLY_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(arm), .sync_in(sync_in),
    .dly(sync_dly), .fire(fire)
  );

  ft_chip_table #(.DEPTH(TBL_N), .W(CHIP_W), .IW(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr),
    .wdata(tbl_data), .last(tbl_last), .advance(chip_wrap),
    .clear(fire), .idx(tbl_idx), .tc(chip_tc)
  );

  ft_level #(.W(SUB_W)) u_sub (
    .clk(clk), .rst_n(rst_n), .step(adv), .load(fire),
    .load_val(init_sub), .tc(sub_tc), .cnt(sub_cnt), .wrap(sub_wrap)
  );

  ft_level #(.W(CHIP_W)) u_chip (
    .clk(clk), .rst_n(rst_n), .step(sub_wrap), .load(fire),
    .load_val(init_chip), .tc(chip_tc), .cnt(chip_cnt), .wrap(chip_wrap)
  );

  ft_level #(.W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .step(chip_wrap), .load(fire),
    .load_val(init_slot), .tc(slot_tc), .cnt(slot_cnt), .wrap(slot_wrap)
  );

  ft_level #(.W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .step(slot_wrap), .load(fire),
    .load_val(init_frame), .tc(frame_tc), .cnt(frame_cnt), .wrap(frame_wrap)
  );

  always_comb begin
    stb_d = '0;
    if (!fire) stb_d = {frame_wrap, slot_wrap, chip_wrap};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= '0;
    else        stb_q <= stb_d;
  end

  assign chip_stb  = stb_q[0];
  assign slot_stb  = stb_q[1];
  assign frame_stb = stb_q[2];
endmodule

// File: rtl/ft_checker.sv
module ft_checker #(
  parameter int unsigned SUB_W   = 8,
  parameter int unsigned CHIP_W  = 16,
  parameter int unsigned SLOT_W  = 8,
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arm,
  input logic               halt,
  input logic               fire,
  input logic               adv,
  input logic [SUB_W-1:0]   sub_tc,
  input logic [SUB_W-1:0]   sub_cnt,
  input logic [CHIP_W-1:0]  chip_cnt,
  input logic [SLOT_W-1:0]  slot_cnt,
  input logic [FRAME_W-1:0] frame_cnt,
  input logic [IDX_W-1:0]   tbl_idx,
  input logic               chip_stb,
  input logic               slot_stb,
  input logic               frame_stb
);
  p_sub_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !fire && sub_cnt == sub_tc) |=> (sub_cnt == '0));

  p_chip_stb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chip_stb |-> (sub_cnt == '0 && chip_cnt == '0));

  p_slot_nest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb |-> (chip_stb && slot_cnt == '0));

  p_frame_nest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (slot_stb && chip_stb && frame_cnt == '0));

  p_load_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (tbl_idx == '0 && !chip_stb));

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !fire) |=> ($stable(sub_cnt) && $stable(chip_cnt) &&
                         $stable(slot_cnt) && $stable(frame_cnt) && $stable(tbl_idx)));

  p_disarm_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !(chip_stb || slot_stb || frame_stb));

  p_disarm_nofire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |-> !fire);
endmodule

bind frame_timebase ft_checker #(
  .SUB_W(SUB_W), .CHIP_W(CHIP_W), .SLOT_W(SLOT_W),
  .FRAME_W(FRAME_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .halt(halt), .fire(fire), .adv(adv),
  .sub_tc(sub_tc), .sub_cnt(sub_cnt), .chip_cnt(chip_cnt), .slot_cnt(slot_cnt),
  .frame_cnt(frame_cnt), .tbl_idx(tbl_idx), .chip_stb(chip_stb),
  .slot_stb(slot_stb), .frame_stb(frame_stb)
);

// File: tb/frame_timebase_test.sv
module frame_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0, halt = 1'b0, sync_in = 1'b0;
  logic [4:0]  sync_dly = '0;
  logic [7:0]  sub_tc = '0, slot_tc = '0, init_sub = '0, init_slot = '0;
  logic [11:0] frame_tc = '0, init_frame = '0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_addr = '0, tbl_last = '0;
  logic [15:0] tbl_data = '0, init_chip = '0;
  logic [7:0]  sub_cnt, slot_cnt;
  logic [15:0] chip_cnt;
  logic [11:0] frame_cnt;
  logic [1:0]  tbl_idx;
  logic        chip_stb, slot_stb, frame_stb;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit model_on = 0;

  // behavioural reference state
  int m_sub, m_chip, m_slot, m_frame, m_idx, m_pend;
  int m_tbl [4];
  bit m_sq, m_cs, m_ss, m_fs;

  always #5 clk = ~clk;

  frame_timebase uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .halt(halt), .sync_in(sync_in),
    .sync_dly(sync_dly), .sub_tc(sub_tc), .slot_tc(slot_tc), .frame_tc(frame_tc),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .tbl_last(tbl_last),
    .init_sub(init_sub), .init_chip(init_chip), .init_slot(init_slot),
    .init_frame(init_frame), .sub_cnt(sub_cnt), .chip_cnt(chip_cnt),
    .slot_cnt(slot_cnt), .frame_cnt(frame_cnt), .tbl_idx(tbl_idx),
    .chip_stb(chip_stb), .slot_stb(slot_stb), .frame_stb(frame_stb)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sub = 0; m_chip = 0; m_slot = 0; m_frame = 0; m_idx = 0; m_pend = 0;
      m_sq = 0; m_cs = 0; m_ss = 0; m_fs = 0;
      for (int i = 0; i < 4; i++) m_tbl[i] = 0;
    end else begin
      bit fire, rise;
      fire = 0;
      rise = arm && sync_in && !m_sq;
      if (!arm) m_pend = 0;
      else begin
        if (m_pend > 0) begin
          if (m_pend == 1) fire = 1;
          m_pend--;
        end
        if (rise) begin
          if (sync_dly == 0) fire = 1;
          else m_pend = sync_dly;
        end
      end
      m_sq = sync_in;
      m_cs = 0; m_ss = 0; m_fs = 0;
      if (fire) begin
        m_sub = init_sub; m_chip = init_chip; m_slot = init_slot;
        m_frame = init_frame; m_idx = 0;
      end else if (arm && !halt) begin
        if (m_sub == sub_tc) begin
          m_sub = 0;
          if (m_chip == m_tbl[m_idx]) begin
            m_chip = 0; m_cs = 1;
            m_idx = (m_idx >= tbl_last) ? 0 : m_idx + 1;
            if (m_slot == slot_tc) begin
              m_slot = 0; m_ss = 1;
              if (m_frame == frame_tc) begin m_frame = 0; m_fs = 1; end
              else m_frame++;
            end else m_slot++;
          end else m_chip++;
        end else m_sub++;
      end
      if (tbl_we) m_tbl[tbl_addr] = tbl_data;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (model_on) begin
      check("R2 sub_cnt", sub_cnt, m_sub);
      check("R3 chip_cnt", chip_cnt, m_chip);
      check("R4 tbl_idx", tbl_idx, m_idx);
      check("R5 slot_cnt", slot_cnt, m_slot);
      check("R6 frame_cnt", frame_cnt, m_frame);
      check("R11 chip_stb", chip_stb, m_cs);
      check("R11 slot_stb", slot_stb, m_ss);
      check("R11 frame_stb", frame_stb, m_fs);
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 2'(a); tbl_data = 16'(d);
    @(negedge clk);
    tbl_we = 0;
  endtask

  initial begin
    int v_sub, v_chip, v_slot, v_frame;
    run(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 sub", sub_cnt, 0); check("R1 chip", chip_cnt, 0);
    check("R1 slot", slot_cnt, 0); check("R1 frame", frame_cnt, 0);
    check("R1 idx", tbl_idx, 0);
    check("R1 strobes", {frame_stb, slot_stb, chip_stb}, 0);
    model_on = 1;

    // variable-length slots: entries 5,2,3 active
    wr(0, 5); wr(1, 2); wr(2, 3); wr(3, 9);
    sub_tc = 3; slot_tc = 2; frame_tc = 1; tbl_last = 2;
    arm = 1;
    run(300);

    // R7 immediate sync load
    init_sub = 1; init_chip = 2; init_slot = 1; init_frame = 0;
    sync_dly = 0; sync_in = 1;
    @(negedge clk);
    check("R7 sub load", sub_cnt, 1); check("R7 chip load", chip_cnt, 2);
    check("R7 slot load", slot_cnt, 1); check("R7 idx clear", tbl_idx, 0);
    run(3); sync_in = 0;   // held level gives no second load
    run(100);

    // R8 + R9: delayed load while halted
    halt = 1;
    @(negedge clk);
    v_sub = sub_cnt; v_chip = chip_cnt; v_slot = slot_cnt; v_frame = frame_cnt;
    init_sub = 2; init_chip = 1; init_slot = 2; init_frame = 1; sync_dly = 3;
    sync_in = 1;
    @(negedge clk); sync_in = 0;
    check("R9 halt hold", sub_cnt, v_sub);
    @(negedge clk);
    check("R8 not yet", chip_cnt, v_chip);
    @(negedge clk);
    check("R8 not yet", slot_cnt, v_slot);
    check("R9 no strobe", chip_stb, 0);
    @(negedge clk);
    check("R8 delayed sub", sub_cnt, 2); check("R8 delayed chip", chip_cnt, 1);
    check("R8 delayed slot", slot_cnt, 2); check("R8 delayed frame", frame_cnt, 1);
    run(5);
    check("R9 halted after load", sub_cnt, 2);
    halt = 0; sync_dly = 0;
    run(100);

    // R10 disarmed: counts frozen, sync ignored
    arm = 0;
    @(negedge clk);
    v_sub = sub_cnt; v_chip = chip_cnt;
    init_sub = 0; init_chip = 0; sync_in = 1;
    run(2); sync_in = 0;
    run(8);
    check("R10 sub frozen", sub_cnt, v_sub);
    check("R10 chip frozen", chip_cnt, v_chip);
    check("R10 strobes", {frame_stb, slot_stb, chip_stb}, 0);
    arm = 1;
    run(100);

    // R4 single active entry
    wr(0, 4); tbl_last = 0;
    run(200);
    check("R4 single entry idx", tbl_idx, 0);

    // typical configuration: 8 sub-chips, 2560 chips, 15 slots
    wr(0, 2559); sub_tc = 7; slot_tc = 14; frame_tc = 12'hFFF;
    init_sub = 0; init_chip = 0; init_slot = 0; init_frame = 0;
    sync_in = 1;
    @(negedge clk); sync_in = 0;
    run(20600);
    check("R5 typical slot", slot_cnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule